// File: doc/BRIEF.md
# Synchronizer Operating Mode Controller

This block is the mode state machine that sits above the digital PLL of a clock synchronizer. It decides whether the loop is running free from the local oscillator, trying to acquire a reference, tracking it, recovering from a phase upset, or holding over after the reference has gone away. Its inputs are status flags from the reference selector and the phase detectors, a control select that takes automatic decisions away, and a millisecond tick used for timekeeping. The loop filter, the detectors and the qualification of input references are outside the block and appear only as these status flags.

The controller reports its mode as a 3-bit code and issues a one-cycle pulse that asks the reference selector to pick a different source whenever an acquisition attempt times out. Two tick-counted intervals shape its behaviour. The first is a lock qualification window: the lock flag must stay high for that many ticks in a row before the tracking mode is declared. The second is an acquisition timeout: if it expires, the controller gives up on the current reference. Both lengths are parameters, with defaults of 1 000 and 100 000 ticks, which are 1 s and 100 s at a 1 ms tick.

When forced control is selected, the internal mode is frozen, both counters are cleared and the reported code reads tracking.

Top module: `sync_mode_ctrl`

## Requirements
- R1: After reset the reported code is 0 (free-running), the reselect request is low and control is automatic.
- R2: From free-running (code 0), the controller moves to acquiring (code 5) on the first clock edge at which `ref_sel` is high.
- R3: The controller declares tracking (code 2) only on the tick at which `phase_lock` has been sampled high on LOCK_TICKS consecutive ticks.
- R4: If `phase_lock` is low on any clock edge, the lock qualification count restarts from zero.
- R5: In acquiring (code 5) or re-acquiring (code 3), the controller returns to free-running (code 0) when TIMEOUT_TICKS ticks pass without lock. The `reselect_req` pulse then goes high for exactly one cycle, in the same cycle as the code becomes 0.
- R6: In tracking with `ref_sel` high, a high `phase_loss` moves the controller to phase-lost (code 6).
- R7: Tracking is reached by lock qualification from acquiring (5), from re-acquiring (3) or from phase-lost (6).
- R8: If `ref_sel` drops while in tracking (2), phase-lost (6) or re-acquiring (3), the controller moves to holdover (code 1).
- R9: In holdover (1), a high `ref_sel` moves the controller to re-acquiring (code 3).
- R10: While `forced_ctrl` is high, the code reported on the next cycle is 2 and `reselect_req` stays low.
- R11: While `forced_ctrl` is high, the internal mode does not change. Automatic operation resumes from the frozen mode when the select drops.
- R12: The codes 4 and 7 are never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle timekeeping tick (1 ms nominal) |
| ref_sel | input | 1 | A reference source is currently selected |
| phase_lock | input | 1 | Phase lock indication from the detectors |
| phase_loss | input | 1 | Phase loss indication from the detectors |
| forced_ctrl | input | 1 | 1 = forced control, 0 = automatic control |
| mode_code | output | 3 | Current mode: 0 free-run, 1 holdover, 2 tracking, 3 re-acquiring, 5 acquiring, 6 phase-lost |
| reselect_req | output | 1 | One-cycle request to choose another reference |

## Verification
Every result is registered, so a change in `mode_code` or `reselect_req` becomes visible one clock after the edge that samples its cause. A lock or timeout becomes visible just after the edge that carries the qualifying tick, not after the next tick. The forced code appears one cycle after `forced_ctrl` rises. The bench changes inputs only on falling edges and reads the outputs at the next falling edge, after the sampling rising edge. A bench model advances on the same rising edges, and each directed check sits exactly on the cycle after the tick or level change that should cause the transition.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    typedef enum logic [2:0] {
        MODE_FREE   = 3'd0,
        MODE_HOLD   = 3'd1,
        MODE_LOCKED = 3'd2,
        MODE_PRE2   = 3'd3,
        MODE_PRE    = 3'd5,
        MODE_LOST   = 3'd6
    } mode_t;

    typedef struct packed {
        mode_t state;
        mode_t code;
        logic  reselect;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RESET = '{state: MODE_FREE, code: MODE_FREE, reselect: 1'b0};

endpackage

// File: rtl/sync_tick_counter.sv
module sync_tick_counter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // terminal tick: the LIMIT-th enabled tick without an intervening clear
    assign done_o = en_i && !clr_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = done_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sync_mode_next.sv
module sync_mode_next
    import sync_mode_pkg::*;
(
    input  mode_t state_i,
    input  logic  forced_i,
    input  logic  ref_sel_i,
    input  logic  phase_loss_i,
    input  logic  lock_done_i,
    input  logic  acq_done_i,
    output mode_t state_o,
    output logic  reselect_o
);
    always_comb begin
        state_o    = state_i;
        reselect_o = 1'b0;
        if (!forced_i) begin
            unique case (state_i)
                MODE_FREE: begin
                    if (ref_sel_i) state_o = MODE_PRE;
                end
                MODE_PRE: begin
                    if (!ref_sel_i) begin
                        state_o = MODE_FREE;
                    end else if (lock_done_i) begin
                        state_o = MODE_LOCKED;
                    end else if (acq_done_i) begin
                        state_o    = MODE_FREE;
                        reselect_o = 1'b1;
                    end
                end
                MODE_PRE2: begin
                    if (!ref_sel_i) begin
                        state_o = MODE_HOLD;
                    end else if (lock_done_i) begin
                        state_o = MODE_LOCKED;
                    end else if (acq_done_i) begin
                        state_o    = MODE_FREE;
                        reselect_o = 1'b1;
                    end
                end
                MODE_LOCKED: begin
                    if (!ref_sel_i) begin
                        state_o = MODE_HOLD;
                    end else if (phase_loss_i) begin
                        state_o = MODE_LOST;
                    end
                end
                MODE_LOST: begin
                    if (!ref_sel_i) begin
                        state_o = MODE_HOLD;
                    end else if (lock_done_i) begin
                        state_o = MODE_LOCKED;
                    end
                end
                MODE_HOLD: begin
                    if (ref_sel_i) state_o = MODE_PRE2;
                end
                default: state_o = MODE_FREE;
            endcase
        end
    end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int LOCK_TICKS    = 1000,
    parameter int TIMEOUT_TICKS = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       ref_sel,
    input  logic       phase_lock,
    input  logic       phase_loss,
    input  logic       forced_ctrl,
    output logic [2:0] mode_code,
    output logic       reselect_req
);
    ctrl_regs_t regs_d, regs_q;

    logic  in_qual, in_acq;
    logic  lock_clr, acq_clr;
    logic  lock_done, acq_done;
    mode_t state_nxt;
    logic  reselect_nxt;

    // modes in which lock qualification and acquisition timeout run
    always_comb begin
        in_qual  = (regs_q.state == MODE_PRE) || (regs_q.state == MODE_PRE2) ||
                   (regs_q.state == MODE_LOST);
        in_acq   = (regs_q.state == MODE_PRE) || (regs_q.state == MODE_PRE2);
        lock_clr = forced_ctrl || !in_qual || !phase_lock;
        acq_clr  = forced_ctrl || !in_acq;
    end

    sync_tick_counter #(.LIMIT(LOCK_TICKS)) u_lock_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (lock_clr),
        .en_i   (tick_ms),
        .done_o (lock_done)
    );

    sync_tick_counter #(.LIMIT(TIMEOUT_TICKS)) u_acq_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (acq_clr),
        .en_i   (tick_ms),
        .done_o (acq_done)
    );

    sync_mode_next u_next (
        .state_i      (regs_q.state),
        .forced_i     (forced_ctrl),
        .ref_sel_i    (ref_sel),
        .phase_loss_i (phase_loss),
        .lock_done_i  (lock_done),
        .acq_done_i   (acq_done),
        .state_o      (state_nxt),
        .reselect_o   (reselect_nxt)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.state    = state_nxt;
        regs_d.code     = forced_ctrl ? MODE_LOCKED : state_nxt;
        regs_d.reselect = reselect_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= CTRL_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode_code    = regs_q.code;
    assign reselect_req = regs_q.reselect;
endmodule

// File: rtl/sync_mode_chk.sv
module sync_mode_chk
    import sync_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ref_sel,
    input logic       phase_lock,
    input logic       phase_loss,
    input logic       forced_ctrl,
    input logic [2:0] mode_code,
    input logic       reselect_req,
    input logic [2:0] state_q
);
    a_r2_free_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced_ctrl && ref_sel && state_q == MODE_FREE) |=> state_q == MODE_PRE);

    a_r3_no_lock_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_PRE && !phase_lock) |=> state_q != MODE_LOCKED);

    a_r5_reselect_single: assert property (@(posedge clk) disable iff (!rst_n)
        reselect_req |=> !reselect_req);

    a_r5_reselect_with_free: assert property (@(posedge clk) disable iff (!rst_n)
        reselect_req |-> mode_code == MODE_FREE);

    a_r6_loss_to_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced_ctrl && ref_sel && phase_loss && state_q == MODE_LOCKED) |=> state_q == MODE_LOST);

    a_r8_ref_gone_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced_ctrl && !ref_sel && (state_q == MODE_LOCKED || state_q == MODE_LOST))
        |=> state_q == MODE_HOLD);

    a_r10_forced_code: assert property (@(posedge clk) disable iff (!rst_n)
        forced_ctrl |=> (mode_code == MODE_LOCKED && !reselect_req));

    a_r11_forced_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        forced_ctrl |=> $stable(state_q));

    a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code != 3'd4 && mode_code != 3'd7);
endmodule

bind sync_mode_ctrl sync_mode_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_sel      (ref_sel),
    .phase_lock   (phase_lock),
    .phase_loss   (phase_loss),
    .forced_ctrl  (forced_ctrl),
    .mode_code    (mode_code),
    .reselect_req (reselect_req),
    .state_q      (regs_q.state)
);

// File: tb/tb_sync_mode_ctrl.sv
module tb_sync_mode_ctrl;
    localparam int L = 8;
    localparam int T = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0, ref_sel = 1'b0, phase_lock = 1'b0;
    logic phase_loss = 1'b0, forced_ctrl = 1'b0;
    logic [2:0] mode_code;
    logic reselect_req;

    int n_run = 0, n_fail = 0, cycles = 0;

    // bench model state
    int m_st = 0, m_lc = 0, m_tc = 0, m_code = 0;
    bit m_rq = 1'b0;

    always #10 clk = ~clk;

    sync_mode_ctrl #(.LOCK_TICKS(L), .TIMEOUT_TICKS(T)) dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ref_sel(ref_sel),
        .phase_lock(phase_lock), .phase_loss(phase_loss), .forced_ctrl(forced_ctrl),
        .mode_code(mode_code), .reselect_req(reselect_req)
    );

    function automatic bit in_set(int s, int a, int b, int c);
        return (s == a) || (s == b) || (s == c);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_lc = 0; m_tc = 0; m_code = 0; m_rq = 0;
        end else begin
            bit lclr, tclr, ldone, tdone;
            int ns;
            lclr  = forced_ctrl || !in_set(m_st, 5, 3, 6) || !phase_lock;
            tclr  = forced_ctrl || !in_set(m_st, 5, 3, 3);
            ldone = tick_ms && !lclr && (m_lc == L - 1);
            tdone = tick_ms && !tclr && (m_tc == T - 1);
            ns = m_st;
            m_rq = 1'b0;
            if (!forced_ctrl) begin
                case (m_st)
                    0: if (ref_sel) ns = 5;
                    5, 3: begin
                        if (!ref_sel) ns = (m_st == 5) ? 0 : 1;
                        else if (ldone) ns = 2;
                        else if (tdone) begin ns = 0; m_rq = 1'b1; end
                    end
                    2: if (!ref_sel) ns = 1; else if (phase_loss) ns = 6;
                    6: if (!ref_sel) ns = 1; else if (ldone) ns = 2;
                    1: if (ref_sel) ns = 3;
                    default: ns = 0;
                endcase
            end
            m_lc = lclr ? 0 : (tick_ms ? (ldone ? 0 : m_lc + 1) : m_lc);
            m_tc = tclr ? 0 : (tick_ms ? (tdone ? 0 : m_tc + 1) : m_tc);
            m_st = ns;
            m_code = forced_ctrl ? 2 : ns;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: apply tick, sample at next falling edge, compare to model
    task automatic cyc(input bit t);
        tick_ms = t;
        @(negedge clk);
        check(int'(mode_code) == m_code, "R12 model code", int'(mode_code), m_code);
        check(reselect_req == m_rq, "R5 model reselect", int'(reselect_req), int'(m_rq));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1);
            cyc(1'b0);
        end
    endtask

    task automatic expect_code(input int exp, input string req);
        check(int'(mode_code) == exp, req, int'(mode_code), exp);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 0);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        expect_code(0, "R1 reset code");
        check(reselect_req == 1'b0, "R1 reset reselect", int'(reselect_req), 0);
        rst_n = 1'b1;
        cyc(1'b0);
        expect_code(0, "R1 idle without reference");

        ref_sel = 1'b1;
        cyc(1'b0);
        expect_code(5, "R2 free to acquiring");

        // R4: partial qualification, dropped lock, restart
        phase_lock = 1'b1;
        ticks(5);
        phase_lock = 1'b0;
        cyc(1'b0);
        phase_lock = 1'b1;
        ticks(L - 1);
        expect_code(5, "R4 restart after drop");
        cyc(1'b1);
        expect_code(2, "R3 lock on final tick");
        cyc(1'b0);

        phase_loss = 1'b1;
        cyc(1'b0);
        phase_loss = 1'b0;
        expect_code(6, "R6 locked to lost");
        ticks(L - 1);
        expect_code(6, "R7 lost still qualifying");
        cyc(1'b1);
        expect_code(2, "R7 lost to locked");
        cyc(1'b0);

        ref_sel = 1'b0;
        cyc(1'b0);
        expect_code(1, "R8 locked to holdover");
        ref_sel = 1'b1;
        cyc(1'b0);
        expect_code(3, "R9 holdover to reacquire");
        ticks(L - 1);
        cyc(1'b1);
        expect_code(2, "R7 reacquire to locked");
        cyc(1'b0);

        // R10 / R11: forced control
        forced_ctrl = 1'b1;
        ref_sel = 1'b0;
        cyc(1'b0);
        expect_code(2, "R10 forced reports locked");
        ticks(3);
        expect_code(2, "R10 forced still locked");
        forced_ctrl = 1'b0;
        ref_sel = 1'b1;
        cyc(1'b0);
        expect_code(2, "R11 state frozen while forced");

        // R5: timeout from re-acquiring, then from acquiring
        ref_sel = 1'b0;
        cyc(1'b0);
        ref_sel = 1'b1;
        phase_lock = 1'b0;
        cyc(1'b0);
        expect_code(3, "R9 reacquire again");
        ticks(T - 1);
        expect_code(3, "R5 no timeout early");
        cyc(1'b1);
        expect_code(0, "R5 timeout to free");
        check(reselect_req == 1'b1, "R5 reselect pulse", int'(reselect_req), 1);
        cyc(1'b0);
        check(reselect_req == 1'b0, "R5 pulse one cycle", int'(reselect_req), 0);
        expect_code(5, "R2 free to acquiring again");
        ticks(T - 1);
        cyc(1'b1);
        expect_code(0, "R5 acquiring timeout");
        check(reselect_req == 1'b1, "R5 acquiring reselect", int'(reselect_req), 1);
        cyc(1'b0);

        // constrained random phase checked against the model
        phase_lock = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(199) == 0) ref_sel = ~ref_sel;
            if ($urandom_range(39) == 0) phase_lock = ~phase_lock;
            if ($urandom_range(399) == 0) forced_ctrl = ~forced_ctrl;
            phase_loss = ($urandom_range(99) == 0);
            cyc($urandom_range(2) == 0);
        end
        finish_run();
    end
endmodule